// File: doc/BRIEF.md
# Monotonic-Switching SAR Conversion Controller

This block sequences one conversion of a fully-differential charge-redistribution successive-approximation converter. It uses the monotonic switching scheme. While the sample input is high, every bottom plate of both capacitor arrays is held at the positive supply and the comparator is kept in reset. When sampling ends, the comparator is released at once and resolves the most significant bit with no capacitor moved.

After each resolved decision, the block grounds exactly one capacitor. That capacitor sits at the current bit position, in the array whose node compared higher. The comparator is then reset for a fixed programmable delay and released again. The delay is counted in system-clock cycles and stands in for a self-timed delay element. A decision counts as valid only when the two latch outputs are complementary. A one-hot pointer walks from the most significant bit to the least significant bit.

After the last bit, the result code is registered and end-of-conversion is raised. The comparator is then held in reset until the next sampling phase. A sample request that arrives during a conversion aborts it.

Top module: `sar_mono_ctrl`

## Requirements
- R1: In the cycle after `sample_i` is seen high at a clock edge, every bit of `cap_p_o` and `cap_n_o` is 1, `cmp_rst_o` is 1 and `eoc_o` is 0. This holds for as long as sampling lasts.
- R2: The first clock edge that sees `sample_i` low drives `cmp_rst_o` to 0. Both capacitor words stay all ones until the first decision.
- R3: A decision taken with the one-hot pointer at bit k clears bit k of `cap_p_o` when `cmp_p_i` is 1, and bit k of `cap_n_o` otherwise. The pointer starts at bit N_BITS-1 and moves down one position per decision. No other bit changes, and no bit position is ever 0 in both words.
- R4: A decision is taken only while `cmp_p_i` and `cmp_n_i` differ. Equal comparator levels (both 0 or both 1) leave the capacitor words, the pointer and `eoc_o` unchanged.
- R5: After each decision except the last, `cmp_rst_o` is high for exactly TD_CYC cycles. It then stays low until the next valid decision, giving N_BITS-1 reset pulses per conversion.
- R6: Bit k of `code_o` is 1 when `cmp_p_i` was 1 at the decision for bit k. `code_o` changes only on the edge where `eoc_o` rises.
- R7: After the least significant decision, `eoc_o` is 1 and `cmp_rst_o` is 1 until sampling starts again. At that point all N_BITS capacitors are grounded in total across the two words.
- R8: `sample_i` seen high during a conversion aborts it. The next cycle shows all capacitor bits at 1, `cmp_rst_o` at 1 and `eoc_o` at 0.
- R9: While `rst_ni` is low, the capacitor words are all ones, `cmp_rst_o` is 1, `eoc_o` is 0 and `code_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sample_i | input | 1 | High during the sampling phase; its fall starts a conversion |
| cmp_p_i | input | 1 | Comparator latch output, high when the positive node is higher |
| cmp_n_i | input | 1 | Comparator latch output, high when the negative node is higher |
| cmp_rst_o | output | 1 | Comparator reset, high to precharge and hold the comparator |
| cap_p_o | output | N_BITS | Positive-array bottom-plate controls, 1 = supply, 0 = ground |
| cap_n_o | output | N_BITS | Negative-array bottom-plate controls, 1 = supply, 0 = ground |
| code_o | output | N_BITS | Result code, registered at end of conversion |
| eoc_o | output | 1 | End of conversion, high from the last decision until sampling |

## Verification
The bench closes the loop with a behavioural comparator. The comparator weighs the input against the grounded capacitors, scaled so that a correct search returns the input value itself as the code. The extreme codes 0 and 1023 drive one array only and exercise the all-ones and all-zeros search paths. The mid-scale pair 511 and 512 and the near-extreme codes separate a wrong first decision from a wrong later one. Random codes then cover mixed switching sequences.

One directed run holds the comparator at equal levels for several cycles, which shows whether the block acts without a valid decision. Another raises the sample input halfway through a conversion and then converts again, which exposes any state left over from the abort.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    ST_SAMPLE = 2'd0,
    ST_EVAL   = 2'd1,
    ST_RST    = 2'd2,
    ST_DONE   = 2'd3
  } sar_state_e;
endpackage

// File: rtl/sar_td_timer.sv
module sar_td_timer #(
  parameter int TD_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic expired_o
);
  localparam int TW = $clog2(TD_CYC + 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= TW'(TD_CYC - 1);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/sar_bit_ptr.sv
module sar_bit_ptr #(
  parameter int N_BITS = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic              step_i,
  input  logic              bit_i,
  output logic [N_BITS-1:0] ptr_o,
  output logic [N_BITS-1:0] res_o
);
  localparam logic [N_BITS-1:0] PTR_MSB = N_BITS'(1) << (N_BITS - 1);

  logic [N_BITS-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ptr_q <= PTR_MSB;
    else if (init_i)  ptr_q <= PTR_MSB;
    else if (step_i)  ptr_q <= ptr_q >> 1;
  end

  // result latch: parked high until its pointer stage is active
  for (genvar k = 0; k < N_BITS; k++) begin : g_res
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  res_o[k] <= 1'b1;
      else if (init_i)              res_o[k] <= 1'b1;
      else if (step_i && ptr_q[k])  res_o[k] <= bit_i;
    end
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/sar_cap_drive.sv
module sar_cap_drive #(
  parameter int N_BITS = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic              step_i,
  input  logic              hi_p_i,
  input  logic [N_BITS-1:0] ptr_i,
  output logic [N_BITS-1:0] cap_p_o,
  output logic [N_BITS-1:0] cap_n_o
);
  for (genvar k = 0; k < N_BITS; k++) begin : g_cap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cap_p_o[k] <= 1'b1;
        cap_n_o[k] <= 1'b1;
      end else if (init_i) begin
        cap_p_o[k] <= 1'b1;
        cap_n_o[k] <= 1'b1;
      end else if (step_i && ptr_i[k]) begin
        // ground only the plate on the side that compared higher
        cap_p_o[k] <= cap_p_o[k] & ~hi_p_i;
        cap_n_o[k] <= cap_n_o[k] &  hi_p_i;
      end
    end
  end
endmodule

// File: rtl/sar_mono_ctrl.sv
module sar_mono_ctrl
  import sar_pkg::*;
#(
  parameter int N_BITS = 10,
  parameter int TD_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_i,
  input  logic              cmp_p_i,
  input  logic              cmp_n_i,
  output logic              cmp_rst_o,
  output logic [N_BITS-1:0] cap_p_o,
  output logic [N_BITS-1:0] cap_n_o,
  output logic [N_BITS-1:0] code_o,
  output logic              eoc_o
);
  sar_state_e        state_q, state_d;
  logic              valid, dec, last, td_expired;
  logic [N_BITS-1:0] ptr, res;

  assign valid = cmp_p_i ^ cmp_n_i;
  assign dec   = (state_q == ST_EVAL) && valid && !sample_i;
  assign last  = ptr[0];

  always_comb begin
    state_d = state_q;
    if (sample_i) state_d = ST_SAMPLE;
    else begin
      unique case (state_q)
        ST_SAMPLE: state_d = ST_EVAL;
        ST_EVAL:   if (dec) state_d = last ? ST_DONE : ST_RST;
        ST_RST:    if (td_expired) state_d = ST_EVAL;
        ST_DONE:   state_d = ST_DONE;
        default:   state_d = ST_SAMPLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_SAMPLE;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          code_o <= '0;
    else if (dec && last) code_o <= {res[N_BITS-1:1], cmp_p_i};
  end

  sar_td_timer #(.TD_CYC(TD_CYC)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (dec && !last),
    .expired_o(td_expired)
  );

  sar_bit_ptr #(.N_BITS(N_BITS)) u_ptr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .init_i(sample_i),
    .step_i(dec),
    .bit_i (cmp_p_i),
    .ptr_o (ptr),
    .res_o (res)
  );

  sar_cap_drive #(.N_BITS(N_BITS)) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .init_i (sample_i),
    .step_i (dec),
    .hi_p_i (cmp_p_i),
    .ptr_i  (ptr),
    .cap_p_o(cap_p_o),
    .cap_n_o(cap_n_o)
  );

  assign cmp_rst_o = (state_q != ST_EVAL);
  assign eoc_o     = (state_q == ST_DONE);
endmodule

// File: rtl/sar_mono_ctrl_chk.sv
module sar_mono_ctrl_chk #(
  parameter int N_BITS = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sample_i,
  input logic              cmp_rst_o,
  input logic [N_BITS-1:0] cap_p_o,
  input logic [N_BITS-1:0] cap_n_o,
  input logic [N_BITS-1:0] code_o,
  input logic              eoc_o
);
  localparam logic [N_BITS-1:0] ALL1 = '1;

  int                gnd_cnt, prev_cnt;
  logic              primed, prev_eoc;
  logic [N_BITS-1:0] prev_code;

  assign gnd_cnt = $countones(~cap_p_o) + $countones(~cap_n_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      primed <= 1'b0; prev_cnt <= 0; prev_eoc <= 1'b0; prev_code <= '0;
    end else begin
      primed <= 1'b1; prev_cnt <= gnd_cnt; prev_eoc <= eoc_o; prev_code <= code_o;
    end
  end

  p_sample_all_high_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_i |=> (cap_p_o == ALL1 && cap_n_o == ALL1 && cmp_rst_o && !eoc_o));

  p_one_side_only_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_p_o | cap_n_o) == ALL1);

  p_single_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed |-> (gnd_cnt == prev_cnt || gnd_cnt == prev_cnt + 1 || gnd_cnt == 0));

  p_eoc_holds_rst_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_o |-> cmp_rst_o);

  p_eoc_all_used_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_o |-> gnd_cnt == N_BITS);

  p_code_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed && !(eoc_o && !prev_eoc)) |-> code_o == prev_code);
endmodule

bind sar_mono_ctrl sar_mono_ctrl_chk #(.N_BITS(N_BITS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sample_i (sample_i),
  .cmp_rst_o(cmp_rst_o),
  .cap_p_o  (cap_p_o),
  .cap_n_o  (cap_n_o),
  .code_o   (code_o),
  .eoc_o    (eoc_o)
);

// File: tb/sar_mono_ctrl_bench.sv
module sar_mono_ctrl_bench;
  localparam int N   = 10;
  localparam int TD  = 4;
  localparam int DEC = 2;
  localparam logic [N-1:0] ALL1 = '1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sample = 1'b1;
  logic         cmp_p, cmp_n, cmp_rst, eoc;
  logic [N-1:0] cap_p, cap_n, code;
  logic         force_eq = 1'b0;
  int           vin = 0;
  int           diff;
  int           dcnt;
  int           n_tests = 0;
  int           n_fail = 0;

  always #10 clk = ~clk;

  sar_mono_ctrl #(.N_BITS(N), .TD_CYC(TD)) u_sar_mono_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .sample_i(sample),
    .cmp_p_i(cmp_p), .cmp_n_i(cmp_n), .cmp_rst_o(cmp_rst),
    .cap_p_o(cap_p), .cap_n_o(cap_n), .code_o(code), .eoc_o(eoc)
  );

  function automatic int wsum(input logic [N-1:0] x);
    return int'(x);
  endfunction

  // differential residue in half-LSB units; correct search yields code == vin
  always_comb diff = 2 * vin + 1 - (1 << N) - wsum(~cap_p) + wsum(~cap_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt <= 0; cmp_p <= 1'b0; cmp_n <= 1'b0;
    end else if (cmp_rst) begin
      dcnt <= 0; cmp_p <= 1'b0; cmp_n <= 1'b0;
    end else begin
      if (dcnt < DEC) dcnt <= dcnt + 1;
      if (dcnt >= DEC - 1) begin
        if (force_eq) begin
          cmp_p <= 1'b1; cmp_n <= 1'b1;
        end else begin
          cmp_p <= (diff > 0); cmp_n <= !(diff > 0);
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic convert(input int v, input bit eq_test);
    int k, run, pulses, rst_err, cap_err, cyc;
    logic [N-1:0] pp, pn, ep, en, held;
    vin = v;
    @(negedge clk); sample = 1'b1;
    repeat (3) @(negedge clk);
    check(cap_p == ALL1 && cap_n == ALL1 && cmp_rst && !eoc, "R1 sampling state",
          int'({cap_p, cap_n}), int'({ALL1, ALL1}));
    force_eq = eq_test;
    sample = 1'b0;
    @(negedge clk);
    check(!cmp_rst && cap_p == ALL1 && cap_n == ALL1, "R2 first compare unswitched",
          int'({cmp_rst, cap_p, cap_n}), int'({1'b0, ALL1, ALL1}));
    if (eq_test) begin
      repeat (12) @(negedge clk);
      check(cap_p == ALL1 && cap_n == ALL1 && !eoc && !cmp_rst, "R4 equal levels ignored",
            int'({eoc, cmp_rst, cap_p, cap_n}), int'({2'b00, ALL1, ALL1}));
      force_eq = 1'b0;
    end
    k = N - 1; run = 0; pulses = 0; rst_err = 0; cap_err = 0; cyc = 0;
    pp = ALL1; pn = ALL1;
    while (!eoc && cyc < 2000) begin
      @(negedge clk); cyc++;
      if (cap_p !== pp || cap_n !== pn) begin
        ep = pp; en = pn;
        if (k >= 0) begin
          if (v[k]) ep[k] = 1'b0; else en[k] = 1'b0;
        end
        if (cap_p !== ep || cap_n !== en) cap_err++;
        pp = cap_p; pn = cap_n; k--;
      end
      if (cmp_rst && !eoc) run++;
      else begin
        if (run != 0) begin
          pulses++;
          if (run != TD) rst_err++;
        end
        run = 0;
      end
    end
    check(eoc == 1'b1, "R7 conversion completes", int'(eoc), 1);
    check(cap_err == 0 && k == -1, "R3 one plate per decision", cap_err, 0);
    check(rst_err == 0 && pulses == N - 1, "R5 reset pulse width/count", pulses, N - 1);
    check(code == v[N-1:0], "R6 result code", int'(code), v);
    held = code;
    repeat (5) @(negedge clk);
    check(eoc && cmp_rst && code == held, "R7 hold after end", int'({eoc, cmp_rst}), 3);
  endtask

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    check(cap_p == ALL1 && cap_n == ALL1 && cmp_rst && !eoc && code == '0, "R9 reset state",
          int'({cmp_rst, eoc, code}), int'({1'b1, 1'b0, {N{1'b0}}}));
    rst_n = 1'b1;
    @(negedge clk);

    convert(0, 1'b0);
    convert(1023, 1'b0);
    convert(511, 1'b0);
    convert(512, 1'b0);
    convert(1, 1'b0);
    convert(1022, 1'b0);
    convert(341, 1'b1);

    // R8: abort mid-conversion
    vin = 682;
    @(negedge clk); sample = 1'b1;
    repeat (2) @(negedge clk);
    sample = 1'b0;
    repeat (25) @(negedge clk);
    check(cap_p != ALL1 || cap_n != ALL1, "R8 abort precondition", 0, 1);
    sample = 1'b1;
    @(negedge clk);
    check(cap_p == ALL1 && cap_n == ALL1 && cmp_rst && !eoc, "R8 abort restores",
          int'({cmp_rst, eoc, cap_p, cap_n}), int'({2'b10, ALL1, ALL1}));
    convert(682, 1'b0);

    for (int i = 0; i < 20; i++) convert(int'($urandom % (1 << N)), 1'b0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule